// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps one write-back cache coherent with its peers on a shared, atomic bus. It holds a tag and a two-bit coherence state for each line of a small direct-mapped array. The processor side presents load, store and replace requests and waits for `cpu_ready`. The bus side requests ownership of the bus, issues read, read-for-ownership, upgrade and writeback commands, and snoops the commands of other caches. Snoop responses are a shared indication (wired-ORed outside the block), a flush indication for dirty data and an optional clean-supply indication. The data array, the arbiter and memory are outside the block. Data movement appears only as these indications.

A read miss fills the line exclusive when no peer raises the shared line at completion, and shared otherwise. An exclusive line can then be written without any bus traffic. A configuration input lets clean holders offer data on a snooped read. Only one transaction is in flight at a time. The processor is held from the miss until the bus reports completion, and the state change is applied in that completion cycle.

Top module: `coh_snoop_ctl`

## Requirements
- R1: After reset every line is invalid; `cpu_state` reports 00 for every address and `bus_req` is low. State codes: invalid 00, shared 01, exclusive 10, modified 11.
- R2: A load that misses issues bus command 00 (read) at `cpu_addr`; at `bus_done` the line becomes exclusive if `shared_in` is low and shared if it is high. Op codes: load 00, store 01, replace 10.
- R3: A load hit, a store to a modified line and a store to an exclusive line complete with `cpu_ready` in the request cycle and with no bus request. The exclusive line becomes modified.
- R4: A store to an invalid line issues command 01 (read-for-ownership), and a store to a shared line issues command 10 (upgrade); each leaves the line modified at `bus_done`.
- R5: A snooped read (00) that hits a modified line raises `flush_out` and leaves the line shared; one that hits an exclusive line leaves it shared without flush.
- R6: A snooped read-for-ownership (01) or upgrade (10) that hits a line invalidates it, raising `flush_out` first if the line was modified.
- R7: `shared_out` is high in any cycle in which a snooped command addresses a valid line with a matching tag, and low otherwise.
- R8: Replacing a modified line issues command 11 (writeback) and invalidates it at `bus_done`; replacing a shared or exclusive line invalidates it silently in the request cycle.
- R9: `supply_out` is high only when `c2c_en` is set and a snooped read hits a shared or exclusive line.
- R10: A load or store miss on an index that holds a modified line with another tag first writes back the victim (command 11 at the victim's address, without `cpu_ready`), then issues the fill.
- R11: `bus_req` stays high from the request through `bus_done`; the command and address hold steady after the grant, `cpu_ready` rises only with `bus_done`, and snoops are ignored while the own transaction is in progress.
- R12: While a request waits for the grant, its command follows the current line state, so a snooped invalidation turns a pending upgrade into a read-for-ownership; a request with no bus need does not complete in a cycle that carries a snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| c2c_en | input | 1 | Enable clean cache-to-cache supply |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_op | input | 2 | Request kind: load, store, replace |
| cpu_addr | input | ADDR_W | Request address (tag above index) |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_state | output | 2 | State of the line at `cpu_addr` (00 on tag mismatch) |
| bus_req | output | 1 | Bus request / ownership |
| bus_cmd | output | 2 | Own bus command |
| bus_addr | output | ADDR_W | Own bus address |
| bus_gnt | input | 1 | Bus grant |
| bus_done | input | 1 | Own transaction completes |
| shared_in | input | 1 | ORed shared line, sampled at `bus_done` of a read |
| snp_valid | input | 1 | A peer command is on the bus |
| snp_cmd | input | 2 | Peer command |
| snp_addr | input | ADDR_W | Peer address |
| shared_out | output | 1 | This cache holds the snooped line |
| flush_out | output | 1 | This cache must flush the snooped line |
| supply_out | output | 1 | This cache offers clean data for the snooped read |

## Verification
The hardest situation to reach is a peer invalidation that arrives while a store to a shared line is waiting for the grant. The upgrade already on `bus_cmd` must then turn into a read-for-ownership before the grant. The bench holds back the grant and drives a peer read-for-ownership to the same address in that cycle. It then checks the command after the snoop and the final modified state. A victim writeback ahead of a fill is reached by storing to a line and then loading an address with the same index and another tag.

// File: rtl/coh_snoop_ctl.sv
module coh_snoop_ctl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c2c_en,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [1:0]        cpu_state,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic              shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              shared_out,
  output logic              flush_out,
  output logic              supply_out
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_RP = 2'd2;

  logic [1:0]        st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic              busy_q, evict_q;
  logic [1:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;

  wire [IDX_W-1:0] c_idx  = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag  = cpu_addr[ADDR_W-1:IDX_W];
  wire [1:0]       c_line = st_q[c_idx];
  wire             c_hit  = (c_line != ST_I) && (tag_q[c_idx] == c_tag);
  wire             vdirty = (c_line == ST_M) && !c_hit;
  assign cpu_state = c_hit ? c_line : ST_I;

  logic       need, evict, loc_wr;
  logic [1:0] want, loc_st;
  always_comb begin
    need = 1'b0; evict = 1'b0; want = C_RD; loc_wr = 1'b0; loc_st = cpu_state;
    case (cpu_op)
      OP_LD: if (!c_hit) begin need = 1'b1; evict = vdirty; want = vdirty ? C_WB : C_RD; end
      OP_ST: case (cpu_state)
        ST_M: ;
        ST_E: begin loc_wr = 1'b1; loc_st = ST_M; end
        ST_S: begin need = 1'b1; want = C_UPG; end
        default: begin need = 1'b1; evict = vdirty; want = vdirty ? C_WB : C_RDX; end
      endcase
      OP_RP: if (cpu_state == ST_M) begin need = 1'b1; want = C_WB; end
             else if (c_hit) begin loc_wr = 1'b1; loc_st = ST_I; end
      default: ;
    endcase
  end

  wire idle_go = cpu_req && !busy_q;
  assign bus_req   = busy_q || (idle_go && need);
  assign bus_cmd   = busy_q ? cmd_q : want;
  assign bus_addr  = busy_q ? addr_q : (evict ? {tag_q[c_idx], c_idx} : cpu_addr);
  assign cpu_ready = busy_q ? (bus_done && !evict_q) : (idle_go && !need && !snp_valid);

  wire [IDX_W-1:0] s_idx  = snp_addr[IDX_W-1:0];
  wire [1:0]       s_line = st_q[s_idx];
  wire s_hit = snp_valid && !busy_q && (s_line != ST_I) &&
               (tag_q[s_idx] == snp_addr[ADDR_W-1:IDX_W]);
  assign shared_out = s_hit;
  assign flush_out  = s_hit && (s_line == ST_M) && (snp_cmd != C_WB);
  assign supply_out = s_hit && c2c_en && (snp_cmd == C_RD) &&
                      ((s_line == ST_S) || (s_line == ST_E));

  wire [IDX_W-1:0] a_idx = addr_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; evict_q <= 1'b0; cmd_q <= C_RD; addr_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else if (busy_q) begin
      if (bus_done) begin
        busy_q <= 1'b0;
        tag_q[a_idx] <= addr_q[ADDR_W-1:IDX_W];
        case (cmd_q)
          C_RD:         st_q[a_idx] <= shared_in ? ST_S : ST_E;
          C_RDX, C_UPG: st_q[a_idx] <= ST_M;
          default:      st_q[a_idx] <= ST_I;
        endcase
      end
    end else begin
      if (bus_req && bus_gnt) begin
        busy_q <= 1'b1; cmd_q <= want; addr_q <= bus_addr; evict_q <= evict;
      end else if (cpu_ready && loc_wr) begin
        st_q[c_idx] <= loc_st;
      end
      if (s_hit && snp_cmd != C_WB)
        st_q[s_idx] <= (snp_cmd == C_RD) ? ST_S : ST_I;
    end
  end
endmodule

// File: rtl/coh_snoop_chk.sv
module coh_snoop_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              c2c_en,
  input logic              busy,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_done,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              shared_out,
  input logic              flush_out,
  input logic              supply_out
);
  assert_flush_is_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_out |-> shared_out && !supply_out);

  assert_supply_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    supply_out |-> c2c_en && snp_cmd == 2'd0);

  assert_hold_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> bus_req && $stable(bus_cmd) && $stable(bus_addr));

  assert_ready_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cpu_ready |-> bus_done);

  assert_invalidated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !busy && snp_cmd == 2'd1 && shared_out) ##1
    (snp_valid && !busy && $stable(snp_addr)) |-> !shared_out);
endmodule

bind coh_snoop_ctl coh_snoop_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .c2c_en(c2c_en), .busy(busy_q),
  .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(bus_cmd),
  .bus_addr(bus_addr), .bus_done(bus_done), .snp_valid(snp_valid),
  .snp_cmd(snp_cmd), .snp_addr(snp_addr), .shared_out(shared_out),
  .flush_out(flush_out), .supply_out(supply_out));

// File: tb/coh_snoop_ctl_bench.sv
module coh_snoop_ctl_bench;
  localparam int AW = 4;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0, c2c_en = 0;
  logic cpu_req = 0; logic [1:0] cpu_op = 0; logic [AW-1:0] cpu_addr = 0;
  logic cpu_ready; logic [1:0] cpu_state;
  logic bus_req; logic [1:0] bus_cmd; logic [AW-1:0] bus_addr;
  logic bus_gnt = 0, bus_done = 0, shared_in = 0;
  logic snp_valid = 0; logic [1:0] snp_cmd = 0; logic [AW-1:0] snp_addr = 0;
  logic shared_out, flush_out, supply_out;

  int checks = 0, errors = 0;
  int mst [4];
  int mtg [4];

  always #4 clk = ~clk;

  coh_snoop_ctl #(.ADDR_W(AW), .IDX_W(IW)) u_coh_snoop_ctl (.*);

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, act, exp);
    end
  endtask

  function automatic int cur(input int a);
    int i = a % 4;
    return (mst[i] != 0 && mtg[i] == a / 4) ? mst[i] : 0;
  endfunction

  task automatic cpu_do(input int op, input int a, input bit sh);
    bit fin = 0;
    int guard = 0;
    @(negedge clk);
    cpu_req = 1; cpu_op = 2'(op); cpu_addr = AW'(a);
    while (!fin && guard < 4) begin
      int idx = a % 4;
      int cs = cur(a);
      bit vd = (mst[idx] == 3) && (cs == 0);
      bit need = 0, ev = 0;
      int cmd = 0, ba = a;
      string t;
      guard++;
      case (op)
        0: if (cs == 0) begin need = 1; ev = vd; cmd = vd ? 3 : 0; end
        1: if (cs == 1) begin need = 1; cmd = 2; end
           else if (cs == 0) begin need = 1; ev = vd; cmd = vd ? 3 : 1; end
        default: if (cs == 3) begin need = 1; cmd = 3; end
      endcase
      if (ev) ba = mtg[idx] * 4 + idx;
      if (!need) t = (op == 2) ? "R8" : "R3";
      else if (ev) t = "R10";
      else if (cmd == 0) t = "R2";
      else if (cmd == 3) t = "R8";
      else t = "R4";
      #1;
      chk(t, "bus_req", bus_req, need);
      if (!need) begin
        chk(t, "cpu_ready", cpu_ready, 1);
        @(negedge clk);
        if (op == 1 && cs == 2) mst[idx] = 3;
        if (op == 2 && cs != 0) mst[idx] = 0;
        fin = 1;
      end else begin
        chk(t, "bus_cmd", bus_cmd, cmd);
        chk(t, "bus_addr", bus_addr, ba);
        chk(t, "cpu_ready before grant", cpu_ready, 0);
        bus_gnt = 1;
        @(negedge clk);
        bus_gnt = 0;
        #1;
        chk("R11", "cpu_ready in flight", cpu_ready, 0);
        chk("R11", "bus_req in flight", bus_req, 1);
        bus_done = 1; shared_in = sh;
        #1;
        chk(t, "cpu_ready at done", cpu_ready, !ev);
        @(negedge clk);
        bus_done = 0; shared_in = 0;
        if (ev || cmd == 3) mst[idx] = 0;
        else begin mst[idx] = (cmd == 0) ? (sh ? 1 : 2) : 3; mtg[idx] = a / 4; end
        if (!ev) fin = 1;
      end
    end
    cpu_req = 0;
  endtask

  task automatic snp_do(input int cmd, input int a, input bit c2c);
    int cs;
    bit hit;
    @(negedge clk);
    cs = cur(a); hit = (cs != 0);
    snp_valid = 1; snp_cmd = 2'(cmd); snp_addr = AW'(a); c2c_en = c2c;
    #1;
    chk("R7", "shared_out", shared_out, hit);
    chk(cmd == 0 ? "R5" : "R6", "flush_out", flush_out, hit && cs == 3 && cmd != 3);
    chk("R9", "supply_out", supply_out, hit && c2c && cmd == 0 && (cs == 1 || cs == 2));
    @(negedge clk);
    snp_valid = 0;
    if (hit && cmd == 0) mst[a % 4] = 1;
    if (hit && (cmd == 1 || cmd == 2)) mst[a % 4] = 0;
  endtask

  task automatic see(input int a, input string r);
    @(negedge clk);
    cpu_addr = AW'(a);
    #1;
    chk(r, "cpu_state", cpu_state, cur(a));
  endtask

  task automatic prep(input int a, input int init);
    int i = a % 4;
    if (mst[i] != 0) cpu_do(2, mtg[i] * 4 + i, 0);
    case (init)
      1: cpu_do(0, a, 1);
      2: cpu_do(0, a, 0);
      3: cpu_do(1, a, 0);
      default: ;
    endcase
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mst[i] = 0; mtg[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 16; a++) see(a, "R1");
    #1 chk("R1", "bus_req", bus_req, 0);

    for (int init = 0; init < 4; init++)
      for (int act = 0; act < 8; act++)
        for (int c = 0; c < 2; c++) begin
          int a = (init * 7 + act * 3 + c * 5) % 16;
          prep(a, init);
          see(a, "R1");
          case (act)
            0: cpu_do(0, a, c);
            1: cpu_do(1, a, 0);
            2: cpu_do(2, a, 0);
            3: snp_do(0, a, c);
            4: snp_do(1, a, c);
            5: snp_do(2, a, c);
            6: snp_do(3, a, c);
            default: snp_do(0, a ^ 4, c);
          endcase
          see(a, act < 3 ? "R4" : "R5");
        end

    // R10: dirty victim on the same index
    prep(1, 3);
    cpu_do(0, 5, 0);
    see(5, "R10"); see(1, "R10");
    prep(2, 3);
    cpu_do(1, 14, 0);
    see(14, "R10");

    // R12: pending upgrade becomes read-for-ownership
    prep(2, 1);
    @(negedge clk);
    cpu_req = 1; cpu_op = 2'd1; cpu_addr = 4'd2;
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 4'd2;
    #1;
    chk("R12", "bus_cmd before snoop", bus_cmd, 2);
    chk("R12", "cpu_ready", cpu_ready, 0);
    @(negedge clk);
    snp_valid = 0; mst[2] = 0;
    #1;
    chk("R12", "bus_cmd after snoop", bus_cmd, 1);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0; bus_done = 1;
    #1 chk("R12", "cpu_ready at done", cpu_ready, 1);
    @(negedge clk);
    bus_done = 0; cpu_req = 0; mst[2] = 3; mtg[2] = 0;
    see(2, "R12");

    // R12: no local completion during a snoop
    prep(0, 0);
    prep(3, 2);
    @(negedge clk);
    cpu_req = 1; cpu_op = 2'd1; cpu_addr = 4'd3;
    snp_valid = 1; snp_cmd = 2'd0; snp_addr = 4'd0;
    #1 chk("R12", "cpu_ready with snoop", cpu_ready, 0);
    @(negedge clk);
    snp_valid = 0;
    #1 chk("R12", "cpu_ready after snoop", cpu_ready, 1);
    @(negedge clk);
    cpu_req = 0; mst[3] = 3;
    see(3, "R3");

    // R11: snoop ignored during own transaction
    prep(1, 2);
    prep(0, 0);
    @(negedge clk);
    cpu_req = 1; cpu_op = 2'd0; cpu_addr = 4'd0;
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 4'd1;
    #1 chk("R11", "shared_out while busy", shared_out, 0);
    bus_done = 1;
    @(negedge clk);
    bus_done = 0; snp_valid = 0; cpu_req = 0; mst[0] = 2; mtg[0] = 0;
    see(1, "R11");
    see(0, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule